// File: doc/BRIEF.md
# Branch Destination Trace Register

This block is a single-entry debug trace register. It records the address of the first instruction fetch that follows a taken branch. The CPU pipeline gives it three inputs: a branch-taken pulse, a fetch strobe and the fetch address. A branch-taken pulse arms the capture. The next fetch strobe loads its address into the register and disarms it, so the sequential fetches that follow leave the captured destination alone.

A debugger polls the register through a 32-bit read port. The top bit of the word is a valid flag, which is set by each capture and cleared as a side effect of a read. Three reserved bits under the flag always read as zero. The low 28 bits carry the captured address. The read data is combinational from the stored state, so a read returns the contents held before the clock edge that ends the read cycle. The block has no write port.

Top module: `brdest_trace`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the valid flag, the arm state and the stored address, so a read after reset returns 32'h0000_0000.
- R2: After a `branchTaken` pulse, the next cycle with `fetchValid` high stores `fetchAddr` in read bits 27:0 and sets the valid flag at read bit 31 to 1.
- R3: Only the first fetch after a branch is captured. Later fetches leave the stored address unchanged until another branch arms the capture again.
- R4: A fetch that occurs while the capture is not armed changes neither the flag nor the address.
- R5: A cycle with `rdEn` high and no capture clears the valid flag to 0 at the end of that cycle, and the stored address is kept.
- R6: Read bits 30:28 are always 0.
- R7: When a capture and a read fall in the same cycle, the read returns the old contents. After that edge the flag is 1 and the new address is stored.
- R8: A fetch in the same cycle as a `branchTaken` pulse is captured only if the capture was already armed. In both cases the capture is armed at the end of that cycle.
- R9: Once armed, the capture stays armed through any number of cycles without a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| branchTaken | input | 1 | One-cycle pulse: a branch was taken |
| fetchValid | input | 1 | An instruction fetch occurs this cycle |
| fetchAddr | input | 28 | Address of the fetch |
| rdEn | input | 1 | Register read this cycle (clears the flag) |
| rdData | output | 32 | {valid, 3'b000, address} |

## Verification
The two functions that can fall in the same cycle are the capture of a destination fetch and the read that clears the flag. The bench arms the capture with a branch and then issues the destination fetch in the very cycle that `rdEn` is high. It expects that read to return the pre-capture word with the flag at 0, and a second read to return the new address with the flag set. A branch pulse that coincides with a fetch is provoked both from the idle state and from the armed state, and is judged by what the next read returns.

// File: rtl/brdest_pkg.sv
package brdest_pkg;
  localparam int ADDR_W = 28;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic capture;
    logic clearFlag;
  } ctrlStrobes_t;
endpackage

// File: rtl/brdest_ctrl.sv
module brdest_ctrl
  import brdest_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         branchTaken,
  input  logic         fetchValid,
  input  logic         rdEn,
  output ctrlStrobes_t strobes
);
  logic armReg;
  logic armNext;

  always_comb begin
    armNext = armReg;
    if (branchTaken)
      armNext = 1'b1;
    else if (fetchValid && armReg)
      armNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) armReg <= 1'b0;
    else     armReg <= armNext;
  end

  always_comb begin
    strobes.capture   = fetchValid && armReg;
    strobes.clearFlag = rdEn;
  end

  // R3: a consumed arm is dropped unless a new branch re-arms it
  a_r3_disarm_after_capture: assert property (@(posedge clk) disable iff (rst)
    (armReg && fetchValid && !branchTaken) |=> !armReg);

  // R8: a branch always leaves the capture armed
  a_r8_branch_arms: assert property (@(posedge clk) disable iff (rst)
    branchTaken |=> armReg);

  // R9: with no fetch and no branch the arm state holds
  a_r9_arm_holds: assert property (@(posedge clk) disable iff (rst)
    (!fetchValid && !branchTaken) |=> $stable(armReg));
endmodule

// File: rtl/brdest_datapath.sv
module brdest_datapath
  import brdest_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [WORD_W-1:0] rdData
);
  localparam int RSV_W = WORD_W - 1 - ADDR_W;

  logic              flagReg;
  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      flagReg <= 1'b0;
      addrReg <= '0;
    end else if (strobes.capture) begin
      flagReg <= 1'b1;
      addrReg <= fetchAddr;
    end else if (strobes.clearFlag) begin
      flagReg <= 1'b0;
    end
  end

  assign rdData = {flagReg, {RSV_W{1'b0}}, addrReg};

  // R2 / R7: a capture sets the flag and stores the address, read or not
  a_r2_capture_loads: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> (flagReg && addrReg == $past(fetchAddr)));

  // R5: a read without a capture clears the flag and keeps the address
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (strobes.clearFlag && !strobes.capture) |=> (!flagReg && $stable(addrReg)));

  // R4: without a capture the address never changes
  a_r4_no_stray_load: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> $stable(addrReg));
endmodule

// File: rtl/brdest_trace.sv
module brdest_trace
  import brdest_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              branchTaken,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData
);
  ctrlStrobes_t strobes;

  brdest_ctrl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .branchTaken (branchTaken),
    .fetchValid  (fetchValid),
    .rdEn        (rdEn),
    .strobes     (strobes)
  );

  brdest_datapath uData (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .fetchAddr (fetchAddr),
    .rdData    (rdData)
  );

  // R6: reserved bits of the read word stay zero
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rdData[WORD_W-2:ADDR_W] == '0);

  // R1: the cycle after reset the word is all zero
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> rdData == '0);
endmodule

// File: tb/tb_brdest_trace.sv
`timescale 1ns/1ps
module tb_brdest_trace;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branchTaken = 1'b0;
  logic        fetchValid = 1'b0;
  logic [27:0] fetchAddr = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;

  int vecCount = 0;
  int errCount = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  logic        mFlag = 1'b0;
  logic        mArm  = 1'b0;
  logic [27:0] mAddr = '0;

  always #2.5 clk = ~clk;

  brdest_trace dut (
    .clk(clk), .rst(rst), .branchTaken(branchTaken), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .rdEn(rdEn), .rdData(rdData)
  );

  task automatic step(input logic br, input logic fv, input logic [27:0] a,
                      input logic rd, input string tag);
    logic cap;
    @(negedge clk);
    branchTaken = br; fetchValid = fv; fetchAddr = a; rdEn = rd;
    #1;
    if (rd) begin
      expQ.push_back({mFlag, 3'b000, mAddr});
      tagQ.push_back(tag);
    end
    cap = fv && mArm;
    if (cap) begin mAddr = a; mFlag = 1'b1; end
    else if (rd) mFlag = 1'b0;
    if (br) mArm = 1'b1;
    else if (fv && mArm) mArm = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 28'h0, 1'b0, "");
  endtask

  // monitor: compares each read against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && rdEn && expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        vecCount++;
        if (rdData !== e) begin
          errCount++;
          $display("FAIL %s: rdData actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errCount++;
      $display("FAIL watchdog (all R): actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(0, 0, 28'h0, 1, "R1 reset state");
    // R4: fetch with nothing armed
    step(0, 1, 28'h0AB_CDEF, 0, "");
    step(0, 0, 28'h0, 1, "R4 unarmed fetch ignored");
    // R2 + R9: branch, idle cycles, then the destination fetch
    step(1, 0, 28'h0, 0, "");
    idle(5);
    step(0, 1, 28'h123_4560, 0, "");
    step(0, 0, 28'h0, 1, "R2 destination captured (R9 arm held)");
    step(0, 0, 28'h0, 1, "R5 flag cleared by read");
    // R3: only the first fetch after a branch
    step(1, 0, 28'h0, 0, "");
    step(0, 1, 28'h000_1000, 0, "");
    step(0, 1, 28'h000_1004, 0, "");
    step(0, 1, 28'h000_1008, 0, "");
    step(0, 0, 28'h0, 1, "R3 first fetch kept");
    // R8: branch with fetch from idle does not capture but arms
    step(1, 1, 28'h0EE_0000, 0, "");
    step(0, 0, 28'h0, 1, "R8 same-cycle fetch not captured");
    step(0, 1, 28'h0EE_0040, 0, "");
    step(0, 0, 28'h0, 1, "R8 arm left set, next fetch captured");
    // R8: armed, branch with fetch captures and re-arms
    step(1, 0, 28'h0, 0, "");
    step(1, 1, 28'h055_0000, 0, "");
    step(0, 0, 28'h0, 1, "R8 armed same-cycle fetch captured");
    step(0, 1, 28'h055_0100, 0, "");
    step(0, 0, 28'h0, 1, "R8 re-armed capture");
    // R7: capture and read in the same cycle
    step(1, 0, 28'h0, 0, "");
    step(0, 1, 28'h0C0_FFEE, 1, "R7 read returns old word");
    step(0, 0, 28'h0, 1, "R7 new address with flag set");
    // R6: all-ones address keeps reserved bits zero
    step(1, 0, 28'h0, 0, "");
    step(0, 1, 28'hFFF_FFFF, 0, "");
    step(0, 0, 28'h0, 1, "R6 reserved bits zero");
    step(0, 0, 28'h0, 1, "R5 address kept after clear");
    // R1: reset mid-run clears everything
    step(1, 0, 28'h0, 0, "");
    @(negedge clk); rst = 1'b1; branchTaken = 0; fetchValid = 0; rdEn = 0;
    @(negedge clk); rst = 1'b0;
    mFlag = 0; mArm = 0; mAddr = '0;
    step(0, 1, 28'h0AA_AAAA, 0, "");
    step(0, 0, 28'h0, 1, "R1 reset clears flag, arm and address");
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule